// File: doc/BRIEF.md
# Capability Memory Access Checker

The block decides whether one memory access made through a capability may go ahead. A capability is a pointer that carries its own validity tag, a sealed flag, a set of permission bits and an allowed address window. For each valid request, the block checks the tag, the seal, the permissions, the window and the alignment together. It reports at most one fault, together with a cause code. A pipeline places the block between address generation and translation. The result is registered, so the verdict appears on the cycle after the request.

Capability loads have one special case. If the authorizer may load data but not capabilities, the load is allowed and the block raises a strip-tag flag, so the loaded value arrives untagged. Capability stores have two extra rules. One concerns the tag of the value being stored. The other concerns whether that value is marked global. An as-user flag forces the effective privilege sent downstream to user mode, whatever the current privilege is.

Top module: `cap_access_chk`

## Requirements
- R1: `rsp_valid` rises exactly one clock after a cycle with `req_valid` high, and is low otherwise. The fault, cause, strip-tag and privilege outputs keep the last verdict until the next request arrives. Synchronous reset clears every output to 0.
- R2: A request whose authorizing capability has a clear tag faults with cause 1.
- R3: A request through a sealed authorizer faults with cause 2.
- R4: Permission bit 0 (load) is needed for data loads (kind 0) and capability loads (kind 2). Permission bit 1 (store) is needed for data stores (kind 1) and capability stores (kind 3). A missing bit faults with cause 3.
- R5: A capability store whose stored value is tagged faults with cause 4 when permission bit 3 (store-capability) is clear. An untagged stored value is not affected by bit 3.
- R6: A capability store faults with cause 5 when all of the following hold: the stored value is tagged, its global bit is clear, and permission bit 4 (store-local) is clear.
- R7: An access faults with cause 6 when either of these holds:
  - the address is below base;
  - address plus size exceeds top.

  The sum is formed at XLEN+1 bits, so it cannot wrap. The size is `data_size` for data kinds and 2*XLEN/8 bytes for capability kinds.
- R8: A capability load or store whose address is not a multiple of 2*XLEN/8 faults with cause 7. Data accesses are never checked for alignment.
- R9: A capability load that has no fault but lacks permission bit 2 (load-capability) raises `clear_tag`. `clear_tag` is low on every faulting response and for every other kind.
- R10: `eff_priv` is 2'b00 (user) when `as_user` is set. Otherwise it equals `cur_priv`.
- R11: When several faults apply, only the lowest-numbered cause is reported. `fault` is high exactly when the cause is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| auth_tag | input | 1 | Authorizer validity tag |
| auth_sealed | input | 1 | Authorizer is sealed |
| auth_perms | input | 5 | Permissions: 0 load, 1 store, 2 load-cap, 3 store-cap, 4 store-local |
| auth_base | input | XLEN | Lowest allowed address |
| auth_top | input | XLEN+1 | One past the highest allowed address |
| auth_addr | input | XLEN | Access address |
| acc_kind | input | 2 | 0 data load, 1 data store, 2 cap load, 3 cap store |
| data_size | input | 4 | Data access size in bytes (1, 2, 4, 8) |
| st_tag | input | 1 | Tag of the capability being stored |
| st_global | input | 1 | Global bit of the capability being stored |
| as_user | input | 1 | Force user privilege |
| cur_priv | input | 2 | Current privilege level |
| rsp_valid | output | 1 | Verdict present |
| fault | output | 1 | Access is refused |
| cause | output | 4 | Fault cause, 0 when none |
| clear_tag | output | 1 | Strip tag of loaded capability |
| eff_priv | output | 2 | Privilege for translation |

## Verification
Most internal errors show up on the cause code on the cycle after the request that triggers them. Examples are a wrong priority between checks, a bounds sum that wraps, or an alignment mask of the wrong width. A faulty strip-tag decision shows up as `clear_tag` on a non-faulting capability load in that same response cycle. A verdict register that fails to hold shows up on the first idle cycle after a request, when the outputs must keep their previous values.

// File: rtl/cap_chk_pkg.sv
package cap_chk_pkg;

    typedef enum logic [1:0] {
        ACC_LD_DATA = 2'd0,
        ACC_ST_DATA = 2'd1,
        ACC_LD_CAP  = 2'd2,
        ACC_ST_CAP  = 2'd3
    } acc_kind_e;

    localparam int PERM_W         = 5;
    localparam int PB_LOAD        = 0;
    localparam int PB_STORE       = 1;
    localparam int PB_LOAD_CAP    = 2;
    localparam int PB_STORE_CAP   = 3;
    localparam int PB_STORE_LOCAL = 4;

    typedef enum logic [3:0] {
        CAUSE_NONE     = 4'd0,
        CAUSE_TAG      = 4'd1,
        CAUSE_SEAL     = 4'd2,
        CAUSE_PERM     = 4'd3,
        CAUSE_CAP_ST   = 4'd4,
        CAUSE_LOCAL_ST = 4'd5,
        CAUSE_BOUNDS   = 4'd6,
        CAUSE_ALIGN    = 4'd7
    } cause_e;

    localparam logic [1:0] PRIV_USER = 2'b00;

    typedef struct packed {
        logic       fault;
        cause_e     cause;
        logic       clr_tag;
        logic [1:0] priv;
    } verdict_t;

    function automatic logic kind_is_store(input acc_kind_e k);
        return (k == ACC_ST_DATA) || (k == ACC_ST_CAP);
    endfunction

    function automatic logic kind_is_cap(input acc_kind_e k);
        return (k == ACC_LD_CAP) || (k == ACC_ST_CAP);
    endfunction

endpackage

// File: rtl/cap_perm_chk.sv
module cap_perm_chk
    import cap_chk_pkg::*;
(
    input  logic              tag,
    input  logic              sealed,
    input  logic [PERM_W-1:0] perms,
    input  acc_kind_e         kind,
    input  logic              st_tag,
    input  logic              st_global,
    output cause_e            perm_cause,
    output logic              strip_tag
);

    logic need_store;
    logic cap_store_tagged;

    assign need_store       = kind_is_store(kind);
    assign cap_store_tagged = (kind == ACC_ST_CAP) && st_tag;

    always_comb begin
        perm_cause = CAUSE_NONE;
        if (!tag)
            perm_cause = CAUSE_TAG;
        else if (sealed)
            perm_cause = CAUSE_SEAL;
        else if (need_store ? !perms[PB_STORE] : !perms[PB_LOAD])
            perm_cause = CAUSE_PERM;
        else if (cap_store_tagged && !perms[PB_STORE_CAP])
            perm_cause = CAUSE_CAP_ST;
        else if (cap_store_tagged && !st_global && !perms[PB_STORE_LOCAL])
            perm_cause = CAUSE_LOCAL_ST;
    end

    assign strip_tag = (kind == ACC_LD_CAP) && !perms[PB_LOAD_CAP];

endmodule

// File: rtl/cap_bounds_chk.sv
module cap_bounds_chk
    import cap_chk_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] addr,
    input  logic [XLEN-1:0] base,
    input  logic [XLEN:0]   top,
    input  acc_kind_e       kind,
    input  logic [3:0]      data_size,
    output logic            out_of_bounds,
    output logic            misaligned
);

    localparam int SW         = XLEN + 1;
    localparam int CAP_BYTES  = (2 * XLEN) / 8;
    localparam int ALIGN_BITS = $clog2(CAP_BYTES);

    logic [SW-1:0] eff_size;
    logic [SW-1:0] end_addr;
    logic          is_cap;

    assign is_cap   = kind_is_cap(kind);
    assign eff_size = is_cap ? SW'(CAP_BYTES) : SW'(data_size);
    assign end_addr = {1'b0, addr} + eff_size;

    assign out_of_bounds = (addr < base) || (end_addr > top);

    generate
        if (ALIGN_BITS > 0) begin : g_align
            assign misaligned = is_cap && (addr[ALIGN_BITS-1:0] != '0);
        end else begin : g_no_align
            assign misaligned = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/cap_verdict_reg.sv
module cap_verdict_reg
    import cap_chk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  verdict_t in_verdict,
    output logic     out_valid,
    output verdict_t out_verdict
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_verdict <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_verdict <= in_verdict;
        end
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R1

    AST_VERDICT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_verdict)); // R1

    AST_STRIP_ONLY_CLEAN: assert property (@(posedge clk) disable iff (rst)
        out_verdict.clr_tag |-> !out_verdict.fault); // R9

endmodule

// File: rtl/cap_access_chk.sv
module cap_access_chk
    import cap_chk_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                auth_tag,
    input  logic                auth_sealed,
    input  logic [PERM_W-1:0]   auth_perms,
    input  logic [XLEN-1:0]     auth_base,
    input  logic [XLEN:0]       auth_top,
    input  logic [XLEN-1:0]     auth_addr,
    input  logic [1:0]          acc_kind,
    input  logic [3:0]          data_size,
    input  logic                st_tag,
    input  logic                st_global,
    input  logic                as_user,
    input  logic [1:0]          cur_priv,
    output logic                rsp_valid,
    output logic                fault,
    output logic [3:0]          cause,
    output logic                clear_tag,
    output logic [1:0]          eff_priv
);

    localparam int CAP_BYTES = (2 * XLEN) / 8;

    acc_kind_e kind;
    cause_e    perm_cause;
    logic      strip_tag;
    logic      oob;
    logic      misal;
    verdict_t  next_v;
    verdict_t  cur_v;

    assign kind = acc_kind_e'(acc_kind);

    cap_perm_chk u_perm (
        .tag        (auth_tag),
        .sealed     (auth_sealed),
        .perms      (auth_perms),
        .kind       (kind),
        .st_tag     (st_tag),
        .st_global  (st_global),
        .perm_cause (perm_cause),
        .strip_tag  (strip_tag)
    );

    cap_bounds_chk #(.XLEN(XLEN)) u_bounds (
        .addr          (auth_addr),
        .base          (auth_base),
        .top           (auth_top),
        .kind          (kind),
        .data_size     (data_size),
        .out_of_bounds (oob),
        .misaligned    (misal)
    );

    always_comb begin
        next_v.cause = CAUSE_NONE;
        if (perm_cause != CAUSE_NONE)
            next_v.cause = perm_cause;
        else if (oob)
            next_v.cause = CAUSE_BOUNDS;
        else if (misal)
            next_v.cause = CAUSE_ALIGN;
        next_v.fault   = (next_v.cause != CAUSE_NONE);
        next_v.clr_tag = !next_v.fault && strip_tag;
        next_v.priv    = as_user ? PRIV_USER : cur_priv;
    end

    cap_verdict_reg u_reg (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (req_valid),
        .in_verdict  (next_v),
        .out_valid   (rsp_valid),
        .out_verdict (cur_v)
    );

    assign fault     = cur_v.fault;
    assign cause     = cur_v.cause;
    assign clear_tag = cur_v.clr_tag;
    assign eff_priv  = cur_v.priv;

    AST_UNTAGGED_FAULTS: assert property (@(posedge clk) disable iff (rst)
        req_valid && !auth_tag |=> fault && cause == 4'd1); // R2

    AST_SEALED_FAULTS: assert property (@(posedge clk) disable iff (rst)
        req_valid && auth_tag && auth_sealed |=> cause == 4'd2); // R3

    AST_CAP_MISALIGN: assert property (@(posedge clk) disable iff (rst)
        req_valid && acc_kind[1] && (auth_addr % CAP_BYTES != 0) |=> fault); // R8

    AST_USER_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
        req_valid && as_user |=> eff_priv == PRIV_USER); // R10

    AST_FAULT_MATCHES_CAUSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> fault == (cause != 4'd0)); // R11

endmodule

// File: tb/cap_access_chk_bench.sv
module cap_access_chk_bench;

    localparam int XLEN = 32;
    localparam int CAPB = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        auth_tag, auth_sealed;
    logic [4:0]  auth_perms;
    logic [31:0] auth_base, auth_addr;
    logic [32:0] auth_top;
    logic [1:0]  acc_kind;
    logic [3:0]  data_size;
    logic        st_tag, st_global, as_user;
    logic [1:0]  cur_priv;
    logic        rsp_valid, fault, clear_tag;
    logic [3:0]  cause;
    logic [1:0]  eff_priv;

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    logic       e_valid = 0, e_fault = 0, e_clr = 0;
    logic [3:0] e_cause = 0;
    logic [1:0] e_priv = 0;

    always #10 clk = ~clk;

    cap_access_chk #(.XLEN(XLEN)) u_cap_access_chk (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .auth_tag(auth_tag), .auth_sealed(auth_sealed), .auth_perms(auth_perms),
        .auth_base(auth_base), .auth_top(auth_top), .auth_addr(auth_addr),
        .acc_kind(acc_kind), .data_size(data_size), .st_tag(st_tag),
        .st_global(st_global), .as_user(as_user), .cur_priv(cur_priv),
        .rsp_valid(rsp_valid), .fault(fault), .cause(cause),
        .clear_tag(clear_tag), .eff_priv(eff_priv)
    );

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5: return "R6";
            4'd6: return "R7";
            4'd7: return "R8";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [3:0] ref_cause();
        longint sz, fin;
        bit st, capk;
        st   = (acc_kind == 2'd1) || (acc_kind == 2'd3);
        capk = (acc_kind >= 2'd2);
        sz   = capk ? CAPB : longint'(data_size);
        fin  = longint'(auth_addr) + sz;
        if (!auth_tag) return 4'd1;
        if (auth_sealed) return 4'd2;
        if (st && !auth_perms[1]) return 4'd3;
        if (!st && !auth_perms[0]) return 4'd3;
        if (acc_kind == 2'd3 && st_tag && !auth_perms[3]) return 4'd4;
        if (acc_kind == 2'd3 && st_tag && !st_global && !auth_perms[4]) return 4'd5;
        if (longint'(auth_addr) < longint'(auth_base) || fin > longint'(auth_top)) return 4'd6;
        if (capk && (auth_addr % CAPB) != 0) return 4'd7;
        return 4'd0;
    endfunction

    task automatic compare(input string what);
        bit bad = 0;
        n_cmp++;
        if (rsp_valid !== e_valid) begin
            bad = 1; $display("FAIL R1 %s rsp_valid act=%0b exp=%0b", what, rsp_valid, e_valid);
        end
        if (cause !== e_cause || fault !== e_fault) begin
            bad = 1;
            $display("FAIL %s %s cause act=%0d/%0b exp=%0d/%0b", tag_of(e_cause), what,
                     cause, fault, e_cause, e_fault);
        end
        if (clear_tag !== e_clr) begin
            bad = 1; $display("FAIL R9 %s clear_tag act=%0b exp=%0b", what, clear_tag, e_clr);
        end
        if (eff_priv !== e_priv) begin
            bad = 1; $display("FAIL R10 %s eff_priv act=%0d exp=%0d", what, eff_priv, e_priv);
        end
        if (bad) n_bad++;
    endtask

    // inputs are held from just after one rising edge to just after the next
    task automatic step(input string what);
        logic [3:0] c;
        c = ref_cause();
        @(posedge clk);
        #1;
        e_valid = req_valid;
        if (req_valid) begin
            e_cause = c;
            e_fault = (c != 0);
            e_clr   = (c == 0) && acc_kind == 2'd2 && !auth_perms[2];
            e_priv  = as_user ? 2'b00 : cur_priv;
        end
        compare(what);
    endtask

    task automatic setup(input logic [1:0] k, input logic [31:0] a, input logic [3:0] sz);
        req_valid = 1; auth_tag = 1; auth_sealed = 0; auth_perms = 5'h1F;
        auth_base = 32'h1000; auth_top = 33'h2000; auth_addr = a;
        acc_kind = k; data_size = sz; st_tag = 0; st_global = 1;
        as_user = 0; cur_priv = 2'b11;
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1;
        setup(2'd0, 32'h1000, 4'd4);
        req_valid = 0;
        repeat (3) @(posedge clk);
        #1;
        compare("reset state R1");
        rst = 0;

        setup(2'd0, 32'h1000, 4'd4); step("clean data load");
        setup(2'd0, 32'h1000, 4'd4); auth_tag = 0; auth_sealed = 1; auth_perms = 0;
        step("untagged beats all R2 R11");
        setup(2'd1, 32'h1000, 4'd4); auth_sealed = 1; auth_perms = 0; step("sealed R3");
        setup(2'd1, 32'h1000, 4'd4); auth_perms = 5'h1D; step("store no perm R4");
        setup(2'd2, 32'h1008, 4'd4); auth_perms = 5'h1E; step("cap load no load perm R4");
        setup(2'd3, 32'h1008, 4'd4); st_tag = 1; auth_perms = 5'h17; step("tagged cap store R5");
        setup(2'd3, 32'h1008, 4'd4); st_tag = 0; auth_perms = 5'h07; step("untagged cap store R5");
        setup(2'd3, 32'h1008, 4'd4); st_tag = 1; st_global = 0; auth_perms = 5'h0F;
        step("local store R6");
        setup(2'd3, 32'h1008, 4'd4); st_tag = 1; st_global = 1; auth_perms = 5'h0F;
        step("global store R6");
        setup(2'd0, 32'h1FFC, 4'd4); step("end equals top R7");
        setup(2'd0, 32'h1FFD, 4'd4); step("one past top R7");
        setup(2'd1, 32'h0FFF, 4'd1); step("below base R7");
        setup(2'd0, 32'hFFFF_FFFF, 4'd8); auth_base = 0; auth_top = 33'h1_0000_0000;
        step("wrap guard R7");
        setup(2'd0, 32'hFFFF_FFF8, 4'd8); auth_base = 0; auth_top = 33'h1_0000_0000;
        step("full top R7");
        setup(2'd2, 32'h1004, 4'd1); step("misaligned cap load R8");
        setup(2'd0, 32'h1003, 4'd4); step("unaligned data ok R8");
        setup(2'd2, 32'h1008, 4'd1); auth_perms = 5'h1B; step("strip tag R9");
        setup(2'd2, 32'h1004, 4'd1); auth_perms = 5'h1B; step("strip tag masked by fault R9");
        setup(2'd0, 32'h1000, 4'd2); as_user = 1; step("as-user override R10");
        setup(2'd0, 32'h1000, 4'd2); cur_priv = 2'b01; step("privilege passthrough R10");
        req_valid = 0; auth_tag = 0; step("idle holds R1");
        step("idle holds again R1");

        for (int i = 0; i < 4000; i++) begin
            req_valid   = ($urandom % 5) != 0;
            auth_tag    = ($urandom % 10) != 0;
            auth_sealed = ($urandom % 10) == 0;
            auth_perms  = (($urandom % 3) == 0) ? 5'($urandom) : 5'h1F;
            auth_base   = $urandom & 32'h0000_FFF8;
            auth_top    = {1'b0, auth_base} + 33'($urandom % 64);
            auth_addr   = auth_base - 32'd8 + ($urandom % 80);
            acc_kind    = 2'($urandom);
            data_size   = 4'(1 << ($urandom % 4));
            st_tag      = 1'($urandom);
            st_global   = 1'($urandom);
            as_user     = 1'($urandom);
            cur_priv    = 2'($urandom);
            step("random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule